// File: doc/BRIEF.md
# Multiply-Accumulate and Divide Unit

This unit sits beside the execute stage of a 32-bit integer pipeline and owns the HI/LO result register pair. The execute stage hands it a 3-bit operation code, two 32-bit operands and a one-cycle issue strobe. Multiplies and multiply-adds finish in the issuing cycle, so the next instruction can read or accumulate into HI/LO with no stall. These operations can be issued every cycle.

Divides are handed to an iterative engine that runs apart from the pipeline. The pipeline keeps moving while a divide runs. The unit reports a stall only when the pipeline asks to read HI/LO before the divide has finished. Any new valid multiply or divide that arrives during a divide cancels the divide in flight.

Top module: `mdu_hilo`

## Requirements
- R1: While reset is held and on the first cycle after it, HI and LO read zero and busy and stall are low. This holds even when a read request is present.
- R2: Operation codes are: 0 signed multiply, 1 unsigned multiply, 2 signed multiply-add, 3 unsigned multiply-add, 4 signed divide, 5 unsigned divide. A multiply (code 0 or 1) with issue high writes the 64-bit product of the operands, upper half to HI and lower half to LO, and the result is visible on the cycle after the issue.
- R3: A multiply-add (code 2 or 3) adds the 64-bit product to the current {HI,LO}, modulo 2^64. Multiply-adds issued on consecutive cycles accumulate one after another with no gap and no stall.
- R4: A divide (code 4 or 5) writes the quotient, truncated toward zero, to LO and the remainder to HI. A signed remainder takes the sign of the dividend. The result appears on HI/LO right after the 35th rising edge that follows the issuing edge.
- R5: busy is high from the cycle after a divide issue until HI/LO take the divide result, exactly 35 cycles. During that time HI/LO keep their previous value.
- R6: stall is high exactly when a HI/LO read request is present while busy is high.
- R7: A multiply issued during a divide writes its product, drops busy at once, and the cancelled quotient is never written. A divide issued during a divide restarts the full 35-cycle count with the new operands.
- R8: A divide by zero still finishes in 35 cycles and drops busy. HI/LO contents are unspecified and no error is raised.
- R9: Codes 6 and 7, and any code while issue is low, have no effect on HI, LO or busy. This also applies while a divide is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Operation issue strobe |
| op_i | input | 3 | Operation code (see R2) |
| rs_i | input | 32 | First operand / dividend |
| rt_i | input | 32 | Second operand / divisor |
| rd_req_i | input | 1 | Pipeline wants to read HI/LO this cycle |
| hi_o | output | 32 | HI register |
| lo_o | output | 32 | LO register |
| busy_o | output | 1 | Divide in flight |
| stall_o | output | 1 | HI/LO read must wait |

## Verification
The hardest conditions to reach from the ports are the collisions between a running divide and new issues. These are a multiply that cancels a divide partway through, a second divide that restarts the count, and a reserved code that must leave the divide untouched. Each must be shown to leave no stale quotient behind. The bench drives these as directed sequences. It counts cycles from the issuing edge, injects the colliding issue at a chosen cycle of the divide, and then idles long enough that any late write would be seen. Random operand pairs, including the most negative dividend over minus one, cover the signed and unsigned arithmetic.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    typedef enum logic [2:0] {
        OP_MUL_S  = 3'd0,
        OP_MUL_U  = 3'd1,
        OP_MAC_S  = 3'd2,
        OP_MAC_U  = 3'd3,
        OP_DIV_S  = 3'd4,
        OP_DIV_U  = 3'd5,
        OP_RSV_6  = 3'd6,
        OP_RSV_7  = 3'd7
    } mdu_op_e;

    function automatic logic op_is_mul(mdu_op_e op);
        return (op == OP_MUL_S) || (op == OP_MUL_U) ||
               (op == OP_MAC_S) || (op == OP_MAC_U);
    endfunction

    function automatic logic op_is_div(mdu_op_e op);
        return (op == OP_DIV_S) || (op == OP_DIV_U);
    endfunction

    function automatic logic op_is_acc(mdu_op_e op);
        return (op == OP_MAC_S) || (op == OP_MAC_U);
    endfunction

    function automatic logic op_is_signed(mdu_op_e op);
        return (op == OP_MUL_S) || (op == OP_MAC_S) || (op == OP_DIV_S);
    endfunction

endpackage

// File: rtl/mdu_mul.sv
module mdu_mul #(
    parameter int W = 32
) (
    input  logic           is_signed_i,
    input  logic           accumulate_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [2*W-1:0] acc_i,
    output logic [2*W-1:0] res_o
);
    localparam int PW = 2 * W;

    logic [PW-1:0] a_ext, b_ext, prod, base;

    always_comb begin
        // Extend to the full product width; the low PW bits of the
        // product are then correct for both signed and unsigned operands.
        a_ext = is_signed_i ? {{W{a_i[W-1]}}, a_i} : {{W{1'b0}}, a_i};
        b_ext = is_signed_i ? {{W{b_i[W-1]}}, b_i} : {{W{1'b0}}, b_i};
        prod  = a_ext * b_ext;
        base  = accumulate_i ? acc_i : '0;
        res_o = base + prod;
    end
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
    parameter int W   = 32,
    parameter int LAT = 35
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         kill_i,
    input  logic         signed_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    // LAT must be at least W+1: W shift steps, then a wait to the fixed count.
    localparam int CW = $clog2(LAT);
    localparam int SW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [SW-1:0] step;
        logic [W:0]    rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
        logic          neg_q;
        logic          neg_r;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [W:0] rem_sh, diff;
    logic       done;

    always_comb begin
        st_d   = st_q;
        rem_sh = {st_q.rem[W-1:0], st_q.quo[W-1]};
        diff   = rem_sh - {1'b0, st_q.dvs};
        done   = st_q.busy && (st_q.cnt == '0);

        if (start_i) begin
            st_d.busy  = 1'b1;
            st_d.cnt   = CW'(LAT - 1);
            st_d.step  = '0;
            st_d.rem   = '0;
            st_d.quo   = (signed_i && dividend_i[W-1]) ? (~dividend_i + 1'b1) : dividend_i;
            st_d.dvs   = (signed_i && divisor_i[W-1])  ? (~divisor_i + 1'b1)  : divisor_i;
            st_d.neg_q = signed_i && (dividend_i[W-1] ^ divisor_i[W-1]);
            st_d.neg_r = signed_i && dividend_i[W-1];
        end else if (kill_i) begin
            st_d.busy = 1'b0;
        end else if (st_q.busy) begin
            if (done) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
            if (st_q.step < SW'(W)) begin
                st_d.step = st_q.step + 1'b1;
                if (!diff[W]) begin
                    st_d.rem = diff;
                    st_d.quo = {st_q.quo[W-2:0], 1'b1};
                end else begin
                    st_d.rem = rem_sh;
                    st_d.quo = {st_q.quo[W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = done;
    assign quo_o  = st_q.neg_q ? (~st_q.quo + 1'b1) : st_q.quo;
    assign rem_o  = st_q.neg_r ? (~st_q.rem[W-1:0] + 1'b1) : st_q.rem[W-1:0];

    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt <= CW'(LAT - 1)));

    assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != '0 && !start_i && !kill_i)
        |=> (st_q.busy && (st_q.cnt + 1'b1 == $past(st_q.cnt))));

    assert_kill_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_i && !start_i) |=> !st_q.busy);

    assert_start_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.busy && st_q.cnt == CW'(LAT - 1)));
endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo #(
    parameter int W       = 32,
    parameter int DIV_LAT = 35
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue_i,
    input  logic [2:0]   op_i,
    input  logic [W-1:0] rs_i,
    input  logic [W-1:0] rt_i,
    input  logic         rd_req_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o,
    output logic         busy_o,
    output logic         stall_o
);
    import mdu_pkg::*;

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
    } hilo_t;

    hilo_t          hl_d, hl_q;
    mdu_op_e        op_e;
    logic           mul_fire, div_fire;
    logic [2*W-1:0] mul_res;
    logic           div_busy, div_done;
    logic [W-1:0]   div_quo, div_rem;

    assign op_e     = mdu_op_e'(op_i);
    assign mul_fire = issue_i && op_is_mul(op_e);
    assign div_fire = issue_i && op_is_div(op_e);

    mdu_mul #(.W(W)) u_mul (
        .is_signed_i  (op_is_signed(op_e)),
        .accumulate_i (op_is_acc(op_e)),
        .a_i          (rs_i),
        .b_i          (rt_i),
        .acc_i        ({hl_q.hi, hl_q.lo}),
        .res_o        (mul_res)
    );

    mdu_div #(.W(W), .LAT(DIV_LAT)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_fire),
        .kill_i     (mul_fire),
        .signed_i   (op_is_signed(op_e)),
        .dividend_i (rs_i),
        .divisor_i  (rt_i),
        .busy_o     (div_busy),
        .done_o     (div_done),
        .quo_o      (div_quo),
        .rem_o      (div_rem)
    );

    always_comb begin
        hl_d = hl_q;
        if (mul_fire) begin
            {hl_d.hi, hl_d.lo} = mul_res;
        end else if (div_done && !div_fire) begin
            hl_d.hi = div_rem;
            hl_d.lo = div_quo;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hl_q <= '0;
        else        hl_q <= hl_d;
    end

    assign hi_o    = hl_q.hi;
    assign lo_o    = hl_q.lo;
    assign busy_o  = div_busy;
    assign stall_o = rd_req_i && div_busy;

    assert_umul_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_i == 3'd1)
        |=> ({hi_o, lo_o} == ({{W{1'b0}}, $past(rs_i)} * {{W{1'b0}}, $past(rt_i)})));

    assert_div_sets_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && (op_i == 3'd4 || op_i == 3'd5)) |=> busy_o);

    assert_hilo_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !issue_i && !div_done) |=> ($stable(hi_o) && $stable(lo_o) && busy_o));

    assert_rsv_noeffect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_i[2:1] == 2'b11 && !busy_o) |=> ($stable(hi_o) && $stable(lo_o) && !busy_o));
endmodule

// File: tb/mdu_hilo_bench.sv
module mdu_hilo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] rs = '0, rt = '0;
    logic        rd_req = 1'b0;
    logic [31:0] hi, lo;
    logic        busy, stall;

    int tests = 0, fails = 0;
    bit finished = 0;
    logic [63:0] m_hl = '0;

    always #5 clk = ~clk;

    mdu_hilo u_mdu_hilo (
        .clk(clk), .rst_n(rst_n), .issue_i(issue), .op_i(op),
        .rs_i(rs), .rt_i(rt), .rd_req_i(rd_req),
        .hi_o(hi), .lo_o(lo), .busy_o(busy), .stall_o(stall)
    );

    function automatic logic [63:0] exp_mul(logic [2:0] o, logic [31:0] a, logic [31:0] b,
                                            logic [63:0] acc);
        logic [63:0] p;
        if (o == 3'd0 || o == 3'd2) p = 64'(longint'($signed(a)) * longint'($signed(b)));
        else                        p = {32'b0, a} * {32'b0, b};
        return (o >= 3'd2) ? acc + p : p;
    endfunction

    function automatic logic [63:0] exp_div(logic sgn, logic [31:0] a, logic [31:0] b);
        longint sa, sb, q, r;
        if (sgn) begin sa = longint'($signed(a)); sb = longint'($signed(b)); end
        else     begin sa = longint'({32'b0, a}); sb = longint'({32'b0, b}); end
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drives an issue at the current negedge, checks at the next one.
    task automatic run_mul(logic [2:0] o, logic [31:0] a, logic [31:0] b);
        issue = 1'b1; op = o; rs = a; rt = b;
        @(negedge clk);
        m_hl = exp_mul(o, a, b, m_hl);
        chk((o >= 3'd2) ? "R3 mac" : "R2 mul", {hi, lo}, m_hl);
    endtask

    // Divide with per-cycle busy/stall/hold checks; poke>0 issues code 7 at that cycle.
    task automatic run_div(logic sgn, logic [31:0] a, logic [31:0] b, bit vals, int poke);
        bit t_ok = 1, s_ok = 1, h_ok = 1;
        issue = 1'b1; op = sgn ? 3'd4 : 3'd5; rs = a; rt = b;
        @(negedge clk);
        issue = 1'b0;
        for (int k = 1; k <= 35; k++) begin
            rd_req = k[0];
            #1;
            if (busy !== 1'b1) t_ok = 0;
            if (stall !== rd_req) s_ok = 0;
            if ({hi, lo} !== m_hl) h_ok = 0;
            if (k == poke) begin issue = 1'b1; op = 3'd7; rs = $urandom; rt = $urandom; end
            else issue = 1'b0;
            @(negedge clk);
        end
        issue = 1'b0;
        rd_req = 1'b1;
        #1;
        chk("R5 busy for 35 cycles", {63'b0, t_ok}, 64'd1);
        chk("R5 hilo held during divide", {63'b0, h_ok}, 64'd1);
        chk("R6 stall tracks read request", {63'b0, s_ok}, 64'd1);
        chk(b == 0 ? "R8 div0 busy drops" : "R4 busy drops at 35", {63'b0, busy}, 64'd0);
        chk("R6 no stall when idle", {63'b0, stall}, 64'd0);
        if (vals) begin
            m_hl = exp_div(sgn, a, b);
            chk(poke > 0 ? "R9 div result after reserved poke" : "R4 div result", {hi, lo}, m_hl);
        end else m_hl = {hi, lo};
        rd_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rd_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset hilo", {hi, lo}, 64'd0);
        chk("R1 reset busy/stall", {62'b0, busy, stall}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {hi, lo, 30'b0, busy, stall} == 0 ? 64'd0 : 64'd1, 64'd0);
        rd_req = 1'b0;

        // R2 directed corners
        run_mul(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_mul(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_mul(3'd0, 32'h8000_0000, 32'h8000_0000);
        run_mul(3'd0, 32'h8000_0000, 32'h7FFF_FFFF);
        // R2/R3 random, back to back every cycle
        for (int i = 0; i < 60; i++) run_mul(3'($urandom_range(0, 3)), $urandom, $urandom);
        // R3 long accumulate chain with wrap
        run_mul(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        for (int i = 0; i < 20; i++) run_mul(3'(2 + (i % 2)), $urandom | 32'hF000_0000, $urandom);
        issue = 1'b0;
        @(negedge clk);
        chk("R3 hold after chain", {hi, lo}, m_hl);

        // R9 reserved codes at idle
        for (int i = 6; i < 8; i++) begin
            issue = 1'b1; op = 3'(i); rs = $urandom; rt = $urandom;
            @(negedge clk);
            issue = 1'b0;
            chk("R9 reserved code no effect", {hi, lo, 31'b0, busy}, {m_hl, 32'b0});
        end
        op = 3'd0; rs = 32'h1234; rt = 32'h5678;
        @(negedge clk);
        chk("R9 issue low no effect", {hi, lo}, m_hl);

        // R4 directed divides
        run_div(1'b1, -32'sd7, 32'sd2, 1, 0);
        run_div(1'b1, 32'sd7, -32'sd2, 1, 0);
        run_div(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 1, 0);
        run_div(1'b0, 32'hFFFF_FFFF, 32'd3, 1, 0);
        run_div(1'b0, 32'd5, 32'd9, 1, 0);
        for (int i = 0; i < 12; i++)
            run_div(1'($urandom), $urandom, $urandom >> $urandom_range(0, 30), 1, 0);
        // R8 divide by zero
        run_div(1'b1, 32'hDEAD_BEEF, 32'd0, 0, 0);
        run_div(1'b0, 32'd77, 32'd0, 0, 0);
        // R9 reserved code during a divide
        run_div(1'b1, -32'sd1000, 32'sd33, 1, 7);

        // R7 multiply cancels a divide
        issue = 1'b1; op = 3'd5; rs = 32'd100; rt = 32'd7;
        @(negedge clk);
        issue = 1'b0;
        repeat (10) @(negedge clk);
        chk("R7 divide still busy", {63'b0, busy}, 64'd1);
        run_mul(3'd1, 32'h0001_0000, 32'h0003_0000);
        issue = 1'b0;
        chk("R7 busy drops on cancel", {63'b0, busy}, 64'd0);
        repeat (40) @(negedge clk);
        chk("R7 cancelled quotient never written", {hi, lo}, m_hl);

        // R7 divide restarts a divide
        issue = 1'b1; op = 3'd4; rs = 32'd999; rt = 32'd4;
        @(negedge clk);
        issue = 1'b0;
        repeat (20) @(negedge clk);
        run_div(1'b1, -32'sd12345, 32'sd10, 1, 0);
        repeat (40) @(negedge clk);
        chk("R7 no late write from old divide", {hi, lo}, m_hl);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule